// File: doc/BRIEF.md
# Staggered Clock Switch Sequencer

This block moves a processor core clock and a system clock off a crystal reference and onto a PLL output without one abrupt frequency jump. On a start request it writes three control fields (source select, core divider, system divider) through five fixed steps. First everything returns to the crystal. Next the core divider is set to halve. Next the system divider is set for the requested core-to-system ratio. Next the source moves to the PLL while the core is still halved. Last the core divider returns to divide-by-one. So in the fast mode a 40 MHz reference steps to 200 MHz and then to 400 MHz, with no direct hop from crystal to full PLL rate.

Consecutive writes are separated by a settle interval of a parameterised number of reference cycles. The block also models the divided clocks as single-cycle enables in the fast clock domain. A crystal tick fires once every `XTAL_DIV` cycles, and the PLL source is active every cycle. The core enable is the source enable divided by the core divider. The system enable is the core enable divided by the system divider. The busy and done flags let the boot controller wait for the switch to finish.

Top module: `clksw_seq_top`

## Requirements
- R1: While reset is held, and after it is released with no start request, all three fields read 12'h000, `busy_o` is 0 and `done_o` is 0.
- R2: A start request sampled while idle writes all three fields to 12'h000 at that same clock edge and raises `busy_o`. The ratio input is captured at this edge.
- R3: `SETTLE_CYCLES` edges after the previous write, the core divider becomes 12'h111 (divide-by-2) while the source select stays 12'h000 (crystal). No field changes in the cycle before this edge.
- R4: `SETTLE_CYCLES` edges later, the system divider becomes 12'h111 if the captured ratio bit was 1 (core:system 1:2), and stays 12'h000 if it was 0 (1:1).
- R5: `SETTLE_CYCLES` edges later, the source select becomes 12'h222 (PLL), and the core divider is still 12'h111 at that edge.
- R6: `SETTLE_CYCLES` edges later, the core divider returns to 12'h000, so the core runs at the full PLL rate.
- R7: `SETTLE_CYCLES` edges after the last write, `done_o` is 1 for exactly one cycle and `busy_o` falls in that same cycle. The fields keep their final values.
- R8: A start request, or a change of the ratio input, while `busy_o` is 1 has no effect on step timing or on any field value.
- R9: The source select and the core divider never change at the same clock edge.
- R10: The core enable fires only on a source tick. The source tick occurs every `XTAL_DIV` cycles when the source is crystal and every cycle when it is PLL. Once the setting has been steady for two core pulses, the core pulse period equals the source period times the core divider (1 or 2).
- R11: The system enable fires only with the core enable. Once steady, its period is the core period times the system divider (1 or 2).
- R12: Each field is 12 bits and holds one 4-bit code repeated three times. Code 0 means crystal or divide-by-1, code 1 means divide-by-2, and code 2 means PLL. No other value ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast (PLL-rate) clock; every enable is in this domain |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to run the switch sequence |
| ratio_half_i | input | 1 | 1 selects core:system 1:2, 0 selects 1:1; captured at start |
| src_sel_o | output | 12 | Clock source select field |
| core_div_o | output | 12 | Core clock divider field |
| sys_div_o | output | 12 | System clock divider field |
| busy_o | output | 1 | High while a sequence is in progress |
| done_o | output | 1 | One-cycle pulse when the sequence has completed |
| core_en_o | output | 1 | Modelled core clock enable |
| sys_en_o | output | 1 | Modelled system clock enable |

## Verification
The sequence is run with both ratio settings, first directed and then drawn at random together with random idle gaps. The 1:2 and 1:1 runs differ only at the system-divider step and in the final system enable period. Some runs inject a start pulse and a flipped ratio input in the middle of a sequence. These show whether the ratio is captured at start or followed live, and whether a busy start restarts the steps. Each field is sampled one cycle before and at each write edge, which separates a correct five-step order and settle spacing from skipped, reordered or early steps. Enable pulse intervals are measured in every field configuration, including the long idle stretches, so a wrong divide or source rate shows up as a period mismatch.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int CODE_W   = 4;
  localparam int CODE_REP = 3;
  localparam int FIELD_W  = CODE_W * CODE_REP;
  localparam int STEP_W   = 3;

  typedef logic [FIELD_W-1:0] field_t;

  localparam logic [CODE_W-1:0] CODE_BASE = 4'd0;
  localparam logic [CODE_W-1:0] CODE_HALF = 4'd1;
  localparam logic [CODE_W-1:0] CODE_PLL  = 4'd2;

  function automatic field_t rep_code(input logic [CODE_W-1:0] c);
    field_t f;
    for (int i = 0; i < CODE_REP; i++) f[i*CODE_W +: CODE_W] = c;
    return f;
  endfunction

  localparam field_t FLD_BASE = rep_code(CODE_BASE);
  localparam field_t FLD_HALF = rep_code(CODE_HALF);
  localparam field_t FLD_PLL  = rep_code(CODE_PLL);

  localparam logic [STEP_W-1:0] FIRST_STEP = 3'd1;
  localparam logic [STEP_W-1:0] LAST_STEP  = 3'd5;

  typedef enum logic {ST_IDLE, ST_SETTLE} seq_state_e;
endpackage

// File: rtl/clksw_settle_timer.sv
module clksw_settle_timer #(
  parameter int SETTLE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic zero_o
);
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(SETTLE - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_n  = load_i ? RELOAD : cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign zero_o = (cnt_q == '0);

  // R3
  tmr_countdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/clksw_step_fsm.sv
module clksw_step_fsm
  import clksw_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   ratio_half_i,
  input  logic   tmr_zero_i,
  output logic   tmr_load_o,
  output field_t src_o,
  output field_t core_o,
  output field_t sys_o,
  output logic   busy_o,
  output logic   done_o
);
  seq_state_e          st_q, st_n;
  logic [STEP_W-1:0]   step_q, step_n;
  field_t              src_q, src_n, core_q, core_n, sys_q, sys_n;
  logic                ratio_q, ratio_n, done_q, done_n, load;

  always_comb begin
    st_n    = st_q;
    step_n  = step_q;
    src_n   = src_q;
    core_n  = core_q;
    sys_n   = sys_q;
    ratio_n = ratio_q;
    done_n  = 1'b0;
    load    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_n    = ST_SETTLE;
          step_n  = FIRST_STEP;
          ratio_n = ratio_half_i;
          load    = 1'b1;
          src_n   = FLD_BASE;
          core_n  = FLD_BASE;
          sys_n   = FLD_BASE;
        end
      end
      ST_SETTLE: begin
        if (tmr_zero_i) begin
          if (step_q == LAST_STEP) begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
          end else begin
            step_n = STEP_W'(step_q + 1'b1);
            load   = 1'b1;
            case (step_q)
              3'd1:    core_n = FLD_HALF;
              3'd2:    sys_n  = ratio_q ? FLD_HALF : FLD_BASE;
              3'd3:    src_n  = FLD_PLL;
              3'd4:    core_n = FLD_BASE;
              default: ;
            endcase
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      step_q  <= '0;
      src_q   <= FLD_BASE;
      core_q  <= FLD_BASE;
      sys_q   <= FLD_BASE;
      ratio_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      step_q <= step_n;
      done_q <= done_n;
      if (load) begin
        src_q  <= src_n;
        core_q <= core_n;
        sys_q  <= sys_n;
      end
      if (st_q == ST_IDLE) ratio_q <= ratio_n;
    end
  end

  assign tmr_load_o = load;
  assign src_o      = src_q;
  assign core_o     = core_q;
  assign sys_o      = sys_q;
  assign busy_o     = (st_q == ST_SETTLE);
  assign done_o     = done_q;

  // R9
  src_core_sep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(src_q) |-> $stable(core_q));
  // R5
  pll_under_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(src_q) && src_q == FLD_PLL) |-> core_q == FLD_HALF);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_o);
  // R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !tmr_zero_i) |=> step_q == $past(step_q));
  // R12
  legal_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q == FLD_BASE || src_q == FLD_PLL) &&
    (core_q == FLD_BASE || core_q == FLD_HALF) &&
    (sys_q == FLD_BASE || sys_q == FLD_HALF));
endmodule

// File: rtl/clksw_enable_gen.sv
module clksw_enable_gen
  import clksw_pkg::*;
#(
  parameter int XTAL_DIV = 10
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  field_t src_i,
  input  field_t core_i,
  input  field_t sys_i,
  output logic   core_en_o,
  output logic   sys_en_o
);
  localparam int XW = (XTAL_DIV > 1) ? $clog2(XTAL_DIV) : 1;

  logic xtal_tick, src_en, core_half, sys_half;
  logic core_ph_q, sys_ph_q;

  generate
    if (XTAL_DIV > 1) begin : g_xtal_cnt
      logic [XW-1:0] xcnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          xcnt_q <= '0;
        else if (xcnt_q == XW'(XTAL_DIV - 1)) xcnt_q <= '0;
        else                                  xcnt_q <= xcnt_q + 1'b1;
      end
      assign xtal_tick = (xcnt_q == XW'(XTAL_DIV - 1));
    end else begin : g_xtal_full
      assign xtal_tick = 1'b1;
    end
  endgenerate

  assign src_en    = (src_i == FLD_PLL) ? 1'b1 : xtal_tick;
  assign core_half = (core_i == FLD_HALF);
  assign sys_half  = (sys_i == FLD_HALF);
  assign core_en_o = src_en & (~core_half | core_ph_q);
  assign sys_en_o  = core_en_o & (~sys_half | sys_ph_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                core_ph_q <= 1'b0;
    else if (!core_half)        core_ph_q <= 1'b0;
    else if (src_en)            core_ph_q <= ~core_ph_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sys_ph_q <= 1'b0;
    else if (!sys_half)         sys_ph_q <= 1'b0;
    else if (core_en_o)         sys_ph_q <= ~sys_ph_q;
  end

  // R10
  core_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_en_o |-> src_en);
  // R10
  core_half_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_en_o && core_half) ##1 core_half |-> !core_en_o);
  // R11
  sys_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_en_o |-> core_en_o);
endmodule

// File: rtl/clksw_seq_top.sv
module clksw_seq_top
  import clksw_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16,
  parameter int XTAL_DIV      = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               ratio_half_i,
  output logic [FIELD_W-1:0] src_sel_o,
  output logic [FIELD_W-1:0] core_div_o,
  output logic [FIELD_W-1:0] sys_div_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               core_en_o,
  output logic               sys_en_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int, tmr_load, tmr_zero;
  field_t     src_w, core_w, sys_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  clksw_settle_timer #(.SETTLE(SETTLE_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .load_i (tmr_load),
    .zero_o (tmr_zero)
  );

  clksw_step_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_int),
    .start_i      (start_i),
    .ratio_half_i (ratio_half_i),
    .tmr_zero_i   (tmr_zero),
    .tmr_load_o   (tmr_load),
    .src_o        (src_w),
    .core_o       (core_w),
    .sys_o        (sys_w),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  clksw_enable_gen #(.XTAL_DIV(XTAL_DIV)) u_en (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .src_i     (src_w),
    .core_i    (core_w),
    .sys_i     (sys_w),
    .core_en_o (core_en_o),
    .sys_en_o  (sys_en_o)
  );

  assign src_sel_o  = src_w;
  assign core_div_o = core_w;
  assign sys_div_o  = sys_w;

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: tb/clksw_seq_top_tb_top.sv
`timescale 1ns/1ps
module clksw_seq_top_tb_top;
  localparam int S   = 64;
  localparam int XD  = 10;
  localparam int WDOG = 150000;
  localparam logic [11:0] F0 = 12'h000, F1 = 12'h111, F2 = 12'h222;

  logic clk = 1'b0;
  logic rst_n, start, ratio_half;
  logic [11:0] src, core, sys;
  logic busy, done, core_en, sys_en;
  int checks = 0, errors = 0;
  longint cyc = 0;
  bit mon_on = 1'b0, finished = 1'b0;

  always #2.5 clk = ~clk;

  clksw_seq_top #(.SETTLE_CYCLES(S), .XTAL_DIV(XD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ratio_half_i(ratio_half),
    .src_sel_o(src), .core_div_o(core), .sys_div_o(sys),
    .busy_o(busy), .done_o(done), .core_en_o(core_en), .sys_en_o(sys_en));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] exp_cfg(input int step, input bit r);
    case (step)
      1: return {F0, F0, F0};
      2: return {F0, F1, F0};
      3: return {F0, F1, r ? F1 : F0};
      4: return {F2, F1, r ? F1 : F0};
      default: return {F2, F0, r ? F1 : F0};
    endcase
  endfunction

  function automatic string step_req(input int step);
    case (step)
      1: return "R2"; 2: return "R3"; 3: return "R4"; 4: return "R5"; default: return "R6";
    endcase
  endfunction

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      finish_up();
    end
  end

  // Enable period monitor (R10, R11) and same-edge change monitor (R9)
  logic [35:0] last_cfg;
  int n_core = 0, n_sys = 0;
  longint lc = 0, ls = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      automatic logic [35:0] cfg = {src, core, sys};
      automatic longint sp = (src == F2) ? 1 : XD;
      automatic longint cp = sp * ((core == F1) ? 2 : 1);
      automatic longint yp = cp * ((sys == F1) ? 2 : 1);
      if (cfg != last_cfg) begin
        chk(!((cfg[35:24] != last_cfg[35:24]) && (cfg[23:12] != last_cfg[23:12])),
            "R9 src/core same edge", cfg, last_cfg);
        n_core = 0; n_sys = 0;
      end
      if (core_en) begin
        if (n_core >= 2) chk(cyc - lc == cp, "R10 core period", cyc - lc, cp);
        if (n_core < 3) n_core++;
        lc = cyc;
      end
      if (sys_en) begin
        chk(core_en, "R11 sys without core", 0, 1);
        if (n_sys >= 2) chk(cyc - ls == yp, "R11 sys period", cyc - ls, yp);
        if (n_sys < 3) n_sys++;
        ls = cyc;
      end
      last_cfg = cfg;
    end
  end

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_seq(input bit r, input bit disturb);
    @(negedge clk);
    ratio_half = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({src, core, sys} == exp_cfg(1, r), "R2 fields", {src, core, sys}, exp_cfg(1, r));
    chk(busy && !done, "R2 busy", {busy, done}, 2'b10);
    for (int k = 2; k <= 5; k++) begin
      if (disturb && k == 3) begin
        wait_neg(2); start = 1'b1; ratio_half = ~r;
        wait_neg(1); start = 1'b0;
        wait_neg(S - 4);
        chk({src, core, sys} == exp_cfg(2, r), "R8 busy start", {src, core, sys}, exp_cfg(2, r));
      end else begin
        wait_neg(S - 1);
        chk({src, core, sys} == exp_cfg(k - 1, r), "R3 early write", {src, core, sys}, exp_cfg(k - 1, r));
      end
      wait_neg(1);
      chk({src, core, sys} == exp_cfg(k, r), step_req(k), {src, core, sys}, exp_cfg(k, r));
    end
    wait_neg(S - 1);
    chk(busy && !done, "R7 before done", {busy, done}, 2'b10);
    wait_neg(1);
    chk(!busy && done, "R7 done pulse", {busy, done}, 2'b01);
    chk({src, core, sys} == exp_cfg(5, r), "R7 final fields", {src, core, sys}, exp_cfg(5, r));
    wait_neg(1);
    chk(!busy && !done, "R7 done one cycle", {busy, done}, 2'b00);
    chk({src, core, sys} == exp_cfg(5, r), "R8 fields held", {src, core, sys}, exp_cfg(5, r));
  endtask

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; start = 1'b0; ratio_half = 1'b0;
    wait_neg(3);
    chk({src, core, sys, busy, done} == 38'd0, "R1 in reset", {src, core, sys, busy, done}, 0);
    rst_n = 1'b1;
    wait_neg(6);
    chk({src, core, sys, busy, done} == 38'd0, "R1 after reset", {src, core, sys, busy, done}, 0);
    last_cfg = {src, core, sys};
    mon_on = 1'b1;
    wait_neg(100);
    // directed: both ratios, then a disturbed run
    run_seq(1'b1, 1'b0);
    wait_neg(120);
    run_seq(1'b0, 1'b0);
    wait_neg(60);
    run_seq(1'b1, 1'b1);
    wait_neg(5);
    // random runs
    for (int i = 0; i < 12; i++) begin
      automatic bit r  = 1'($urandom_range(0, 1));
      automatic bit d  = 1'($urandom_range(0, 1));
      automatic int gp = $urandom_range(0, 90);
      run_seq(r, d);
      wait_neg(gp);
    end
    wait_neg(200);
    finish_up();
  end
endmodule